// File: doc/BRIEF.md
# Decode-stage branch resolver

This unit settles conditional branches while the branch is still in the decode stage of a five-stage pipeline. Each cycle it forms a branch destination from the decode-stage program counter and the instruction's immediate field. It also decides an equal or not-equal test on the two source registers. Resolving the branch this early means a taken branch costs only the one instruction that is being fetched in the same cycle.

The two compared values usually come from the register file. They can also be bypassed from the register after the execute stage or from the register after the memory stage. This bypass path belongs to the comparator alone and is separate from the ALU operand bypass. Some values cannot arrive in time. One case is a result still being computed by the instruction right ahead of the branch. Another is load data that has not yet left the memory stage. In either case the unit asks decode to hold, and it withholds its taken decision until the operand is available.

Top module: `branch_resolve_unit`

## Requirements
- R1: `br_target` equals `id_pc + 4 + (sign-extended id_imm << 2)` in every cycle, whatever the value of `id_br_kind`.
- R2: With `id_br_kind` = 2'b01 (branch if equal) and no stall, `br_taken` is 1 exactly when the two resolved operands are bitwise identical.
- R3: With `id_br_kind` = 2'b10 (branch if not equal) and no stall, `br_taken` is 1 exactly when the two resolved operands differ in at least one bit.
- R4: A source register that matches `mem_rd`, with `mem_wr_en`=1 and `mem_is_load`=0, takes its value from `mem_result` in place of the register-file data.
- R5: A source register that matches `wb_rd` with `wb_wr_en`=1, and is not supplied by R4, takes its value from `wb_data`.
- R6: When both later stages match the same source register, the value from the memory-stage register (`mem_result`) wins.
- R7: A source register index of 0 is never bypassed. It always uses its register-file data and never causes a stall.
- R8: During a branch, `br_stall` is 1 when `ex_wr_en`=1 and `ex_rd` matches either nonzero source register.
- R9: During a branch, `br_stall` is 1 when `mem_wr_en`=1, `mem_is_load`=1 and `mem_rd` matches either nonzero source register. A load that sits just ahead of its dependent branch therefore holds decode for exactly two cycles.
- R10: `br_taken` is 0 in every cycle in which `br_stall` is 1.
- R11: When `id_br_kind` is 2'b00 or 2'b11 (not a branch), `br_stall` and `br_taken` are both 0, whatever the hazard inputs are.
- R12: A later stage whose write enable is 0, or whose destination does not match, has no effect on the operands and raises no stall.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| id_br_kind | input | 2 | 01 branch if equal, 10 branch if not equal, otherwise no branch |
| id_pc | input | XLEN | Program counter of the instruction in decode |
| id_imm | input | IMM_W | Immediate field, word offset |
| id_rs | input | RA_W | First source register index |
| id_rt | input | RA_W | Second source register index |
| rf_rs_data | input | XLEN | Register-file read data for id_rs |
| rf_rt_data | input | XLEN | Register-file read data for id_rt |
| ex_wr_en | input | 1 | Instruction in execute writes a register |
| ex_rd | input | RA_W | Destination of the instruction in execute |
| mem_wr_en | input | 1 | Instruction in memory stage writes a register |
| mem_is_load | input | 1 | Instruction in memory stage is a load |
| mem_rd | input | RA_W | Destination of the instruction in memory stage |
| mem_result | input | XLEN | ALU result held after the execute stage |
| wb_wr_en | input | 1 | Instruction in write-back writes a register |
| wb_rd | input | RA_W | Destination of the instruction in write-back |
| wb_data | input | XLEN | Value held after the memory stage |
| br_taken | output | 1 | Branch resolved as taken this cycle |
| br_target | output | XLEN | Branch destination address |
| br_stall | output | 1 | Hold decode and fetch for one cycle |

## Verification
Bypass and stall can both apply in the same cycle. The bench provokes this by pairing one source that hits the write-back stage with the other source that hits an instruction still in execute. The bench then expects the stall, with the taken flag low, even though the bypassed value would have settled the comparison. A second collision sets the memory and write-back destinations to the same register with different values. Here the outcome of an equal test shows which of the two values was picked. A randomized phase draws register indices from a tiny range, so that such coincidences occur often. Each cycle is judged against a behavioural model.

// File: rtl/branch_resolve_unit.sv
module branch_resolve_unit #(
  parameter int XLEN  = 32,
  parameter int RA_W  = 5,
  parameter int IMM_W = 16
) (
  input  logic [1:0]      id_br_kind,
  input  logic [XLEN-1:0] id_pc,
  input  logic [IMM_W-1:0] id_imm,
  input  logic [RA_W-1:0] id_rs,
  input  logic [RA_W-1:0] id_rt,
  input  logic [XLEN-1:0] rf_rs_data,
  input  logic [XLEN-1:0] rf_rt_data,
  input  logic            ex_wr_en,
  input  logic [RA_W-1:0] ex_rd,
  input  logic            mem_wr_en,
  input  logic            mem_is_load,
  input  logic [RA_W-1:0] mem_rd,
  input  logic [XLEN-1:0] mem_result,
  input  logic            wb_wr_en,
  input  logic [RA_W-1:0] wb_rd,
  input  logic [XLEN-1:0] wb_data,
  output logic            br_taken,
  output logic [XLEN-1:0] br_target,
  output logic            br_stall
);
  localparam int              SHIFT      = 2;
  localparam logic [XLEN-1:0] INSN_BYTES = XLEN'(4);
  localparam logic [1:0]      KIND_EQ    = 2'b01;
  localparam logic [1:0]      KIND_NE    = 2'b10;

  logic [XLEN-1:0] imm_ext;
  assign imm_ext   = {{(XLEN-IMM_W){id_imm[IMM_W-1]}}, id_imm};
  assign br_target = id_pc + INSN_BYTES + (imm_ext << SHIFT);

  logic [1:0][RA_W-1:0] src;
  logic [1:0][XLEN-1:0] rf_val;
  logic [1:0][XLEN-1:0] opnd;
  logic [1:0]           haz;

  assign src[0]    = id_rs;
  assign src[1]    = id_rt;
  assign rf_val[0] = rf_rs_data;
  assign rf_val[1] = rf_rt_data;

  for (genvar g = 0; g < 2; g++) begin : g_port
    logic live, hit_mem, hit_wb, hit_ex, hit_load;
    assign live     = |src[g];
    assign hit_mem  = live && mem_wr_en && !mem_is_load && (mem_rd == src[g]);
    assign hit_wb   = live && wb_wr_en && (wb_rd == src[g]);
    assign hit_ex   = live && ex_wr_en && (ex_rd == src[g]);
    assign hit_load = live && mem_wr_en && mem_is_load && (mem_rd == src[g]);
    assign opnd[g]  = hit_mem ? mem_result : (hit_wb ? wb_data : rf_val[g]);
    assign haz[g]   = hit_ex || hit_load;
  end

  logic is_br, same;
  assign is_br    = (id_br_kind == KIND_EQ) || (id_br_kind == KIND_NE);
  assign same     = ~|(opnd[0] ^ opnd[1]);
  assign br_stall = is_br && |haz;
  assign br_taken = is_br && !br_stall && ((id_br_kind == KIND_EQ) ? same : !same);
endmodule

module branch_resolve_unit_chk #(
  parameter int RA_W = 5
) (
  input logic [1:0]      id_br_kind,
  input logic [RA_W-1:0] id_rs,
  input logic [RA_W-1:0] id_rt,
  input logic            ex_wr_en,
  input logic [RA_W-1:0] ex_rd,
  input logic            mem_wr_en,
  input logic            mem_is_load,
  input logic [RA_W-1:0] mem_rd,
  input logic            br_taken,
  input logic            br_stall
);
  logic branch, ex_dep, ld_dep;
  assign branch = (id_br_kind == 2'b01) || (id_br_kind == 2'b10);
  assign ex_dep = ex_wr_en && (ex_rd != '0) && (ex_rd == id_rs || ex_rd == id_rt);
  assign ld_dep = mem_wr_en && mem_is_load && (mem_rd != '0) &&
                  (mem_rd == id_rs || mem_rd == id_rt);

  always_comb begin
    // R10
    stall_blocks_taken_chk: assert (!(br_stall && br_taken))
      else $error("taken raised during stall");
    // R11
    idle_quiet_chk: assert (branch || (!br_stall && !br_taken))
      else $error("non-branch produced stall or taken");
    // R8
    ex_hazard_chk: assert (!(branch && ex_dep) || br_stall)
      else $error("missing stall for execute-stage producer");
    // R9
    load_hazard_chk: assert (!(branch && ld_dep) || br_stall)
      else $error("missing stall for pending load");
    // R12
    stall_cause_chk: assert (!br_stall || ex_dep || ld_dep)
      else $error("stall without a hazard");
  end
endmodule

bind branch_resolve_unit branch_resolve_unit_chk #(.RA_W(RA_W)) u_chk (
  .id_br_kind(id_br_kind), .id_rs(id_rs), .id_rt(id_rt),
  .ex_wr_en(ex_wr_en), .ex_rd(ex_rd),
  .mem_wr_en(mem_wr_en), .mem_is_load(mem_is_load), .mem_rd(mem_rd),
  .br_taken(br_taken), .br_stall(br_stall)
);

// File: tb/tb_branch_resolve_unit.sv
module tb_branch_resolve_unit;
  logic clk = 0;
  logic rst_n = 0;
  always #5 clk = ~clk;

  logic [1:0]  id_br_kind;
  logic [31:0] id_pc;
  logic [15:0] id_imm;
  logic [4:0]  id_rs, id_rt, ex_rd, mem_rd, wb_rd;
  logic [31:0] rf_rs_data, rf_rt_data, mem_result, wb_data;
  logic        ex_wr_en, mem_wr_en, mem_is_load, wb_wr_en;
  logic        br_taken, br_stall;
  logic [31:0] br_target;

  branch_resolve_unit dut (.*);

  int checks = 0, errors = 0, cycles = 0;
  bit done = 0;

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000 && !done) begin
      errors++;
      $display("FAIL watchdog: actual %0d cycles, expected under 100000", cycles);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic idle();
    id_br_kind = 0; id_pc = 0; id_imm = 0; id_rs = 0; id_rt = 0;
    rf_rs_data = 0; rf_rt_data = 0;
    ex_wr_en = 0; ex_rd = 0;
    mem_wr_en = 0; mem_is_load = 0; mem_rd = 0; mem_result = 0;
    wb_wr_en = 0; wb_rd = 0; wb_data = 0;
  endtask

  function automatic logic [31:0] pick(logic [4:0] r, logic [31:0] rf);
    if (r == 0) return rf;
    if (mem_wr_en && !mem_is_load && mem_rd == r) return mem_result;
    if (wb_wr_en && wb_rd == r) return wb_data;
    return rf;
  endfunction

  function automatic bit blocked(logic [4:0] r);
    if (r == 0) return 0;
    if (ex_wr_en && ex_rd == r) return 1;
    if (mem_wr_en && mem_is_load && mem_rd == r) return 1;
    return 0;
  endfunction

  task automatic check_now(string tag);
    int off;
    logic [31:0] e_tgt;
    bit e_stall, e_taken, isbr;
    off = $signed(id_imm);
    e_tgt = id_pc + 32'd4 + 32'(off * 4);
    isbr = (id_br_kind == 2'b01 || id_br_kind == 2'b10);
    e_stall = isbr && (blocked(id_rs) || blocked(id_rt));
    e_taken = 0;
    if (isbr && !e_stall) begin
      if (id_br_kind == 2'b01) e_taken = (pick(id_rs, rf_rs_data) == pick(id_rt, rf_rt_data));
      else                     e_taken = (pick(id_rs, rf_rs_data) != pick(id_rt, rf_rt_data));
    end
    checks += 3;
    if (br_target !== e_tgt) begin
      errors++;
      $display("FAIL %s target: actual %h expected %h", tag, br_target, e_tgt);
    end
    if (br_stall !== e_stall) begin
      errors++;
      $display("FAIL %s stall: actual %b expected %b", tag, br_stall, e_stall);
    end
    if (br_taken !== e_taken) begin
      errors++;
      $display("FAIL %s taken: actual %b expected %b", tag, br_taken, e_taken);
    end
  endtask

  task automatic step(string tag);
    @(negedge clk);
    check_now(tag);
  endtask

  task automatic expect_bit(string tag, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %b expected %b", tag, act, exp);
    end
  endtask

  initial begin
    idle();
    repeat (3) @(negedge clk);
    rst_n = 1;
    step("reset idle");
    expect_bit("reset stall", br_stall, 1'b0);

    // R1 target with positive, negative offsets and no branch
    id_pc = 32'h0000_1000; id_imm = 16'h0010; step("R1 pos");
    id_imm = 16'hFFFC; step("R1 neg");
    id_pc = 32'hFFFF_FFF8; id_imm = 16'h0001; step("R1 wrap");

    // R2 equal
    idle(); id_br_kind = 2'b01; id_rs = 5'd3; id_rt = 5'd4;
    rf_rs_data = 32'hCAFE; rf_rt_data = 32'hCAFE; step("R2 eq");
    expect_bit("R2 eq taken", br_taken, 1'b1);
    rf_rt_data = 32'h8000_CAFE; step("R2 msb diff");
    // R3 not equal
    id_br_kind = 2'b10; step("R3 ne");
    expect_bit("R3 ne taken", br_taken, 1'b1);
    rf_rt_data = 32'hCAFE; step("R3 same");

    // R4 bypass from memory-stage register
    idle(); id_br_kind = 2'b01; id_rs = 5'd7; id_rt = 5'd8;
    rf_rs_data = 32'h1; rf_rt_data = 32'h55;
    mem_wr_en = 1; mem_rd = 5'd7; mem_result = 32'h55; step("R4 mem fwd");
    expect_bit("R4 taken", br_taken, 1'b1);
    // R5 bypass from write-back
    idle(); id_br_kind = 2'b01; id_rs = 5'd7; id_rt = 5'd8;
    rf_rs_data = 32'h55; rf_rt_data = 32'h2;
    wb_wr_en = 1; wb_rd = 5'd8; wb_data = 32'h55; step("R5 wb fwd");
    expect_bit("R5 taken", br_taken, 1'b1);
    // R6 priority
    mem_wr_en = 1; mem_rd = 5'd8; mem_result = 32'h99; step("R6 prio");
    expect_bit("R6 taken", br_taken, 1'b0);
    mem_result = 32'h55; step("R6 prio eq");
    // R12 write enable low / mismatch
    mem_wr_en = 0; wb_wr_en = 0; step("R12 wen low");
    expect_bit("R12 taken", br_taken, 1'b0);
    ex_wr_en = 1; ex_rd = 5'd9; step("R12 mismatch");
    // R7 register 0
    idle(); id_br_kind = 2'b01; id_rs = 0; id_rt = 5'd2;
    rf_rs_data = 32'h0; rf_rt_data = 32'h0;
    mem_wr_en = 1; mem_rd = 0; mem_result = 32'h7;
    wb_wr_en = 1; wb_rd = 0; wb_data = 32'h8;
    ex_wr_en = 1; ex_rd = 0; step("R7 zero");
    expect_bit("R7 taken", br_taken, 1'b1);
    expect_bit("R7 stall", br_stall, 1'b0);

    // R8 producer in execute, collides with a bypass on the other source
    idle(); id_br_kind = 2'b10; id_rs = 5'd5; id_rt = 5'd6;
    rf_rs_data = 32'h3; rf_rt_data = 32'h4;
    wb_wr_en = 1; wb_rd = 5'd6; wb_data = 32'h3;
    ex_wr_en = 1; ex_rd = 5'd5; step("R8 ex hazard");
    expect_bit("R8 stall", br_stall, 1'b1);
    expect_bit("R10 taken low", br_taken, 1'b0);
    // R11 non-branch ignores hazards
    id_br_kind = 2'b00; step("R11 kind00");
    expect_bit("R11 stall", br_stall, 1'b0);
    id_br_kind = 2'b11; step("R11 kind11");

    // R9 load ahead of branch: two stalled cycles then resolve
    idle(); id_br_kind = 2'b01; id_rs = 5'd10; id_rt = 5'd11;
    rf_rs_data = 32'h0; rf_rt_data = 32'hBEEF;
    ex_wr_en = 1; ex_rd = 5'd10; step("R9 load in ex");
    expect_bit("R9 stall1", br_stall, 1'b1);
    ex_wr_en = 0; mem_wr_en = 1; mem_is_load = 1; mem_rd = 5'd10;
    mem_result = 32'hBEEF; step("R9 load in mem");
    expect_bit("R9 stall2", br_stall, 1'b1);
    mem_wr_en = 0; mem_is_load = 0;
    wb_wr_en = 1; wb_rd = 5'd10; wb_data = 32'hBEEF; step("R9 load in wb");
    expect_bit("R9 resolved", br_taken, 1'b1);

    // randomized mix, tiny register range to force coincidences
    for (int i = 0; i < 400; i++) begin
      id_br_kind = 2'($urandom); id_pc = $urandom; id_imm = 16'($urandom);
      id_rs = 5'($urandom_range(0, 3)); id_rt = 5'($urandom_range(0, 3));
      rf_rs_data = 32'($urandom_range(0, 2)); rf_rt_data = 32'($urandom_range(0, 2));
      ex_wr_en = 1'($urandom); ex_rd = 5'($urandom_range(0, 3));
      mem_wr_en = 1'($urandom); mem_is_load = 1'($urandom_range(0, 3) == 0);
      mem_rd = 5'($urandom_range(0, 3)); mem_result = 32'($urandom_range(0, 2));
      wb_wr_en = 1'($urandom); wb_rd = 5'($urandom_range(0, 3));
      wb_data = 32'($urandom_range(0, 2));
      step("R2 R3 R4 R5 R6 R8 R9 random");
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule